// File: doc/BRIEF.md
# Transmit clock presence monitor

The monitor decides whether the clock feeding the transmit line side is alive. It runs on a reference clock that is present at all times. Once per fixed interval of reference cycles it checks whether the watched clock produced any rising edge during that interval. If it did not, a loss flag is raised and both line driver enables are pulled low, so that nothing reaches the line.

A select input picks which clock is watched. When jitter smoothing sits in the transmit path, its output clock is watched. Otherwise the plain transmit clock is watched. The watched clock is brought into the reference domain through a synchronizer, and its rising edges are found there. Because of this, the watched clock must run slower than half the reference rate.

Top module: `txclk_watch`

## Requirements
- R1: An evaluation strobe occurs every DIV reference cycles (DIV defaults to 10). The first strobe falls on the DIV-th rising reference edge after reset is released. The loss flag changes only on a strobe edge.
- R2: If the watched clock had at least one rising edge in the interval before a strobe, the loss flag is 0 after that strobe.
- R3: If the watched clock had no rising edge in the interval before a strobe, the loss flag is 1 after that strobe.
- R4: While the loss flag is 1, drv_en_p and drv_en_n are both 0. While it is 0, both are 1.
- R5: When src_sel is 1, smooth_clk is watched. When src_sel is 0, tx_clk is watched. The clock that is not selected has no effect on the loss flag.
- R6: The watched clock passes through a two-stage synchronizer clocked by ref_clk. Any watched clock whose period is shorter than DIV reference cycles, but at least 4 reference cycles, keeps the loss flag at 0.
- R7: The record of a seen edge is cleared at every strobe. After the watched clock stops, the loss flag rises within two intervals plus the synchronizer latency.
- R8: During reset, and after reset until the first strobe, the loss flag is 1 and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_clk | input | 1 | Transmit clock candidate |
| smooth_clk | input | 1 | Clock from the jitter smoother |
| src_sel | input | 1 | 1 = watch smooth_clk, 0 = watch tx_clk |
| loss | output | 1 | Watched clock absent during the last interval |
| drv_en_p | output | 1 | Positive line driver enable |
| drv_en_n | output | 1 | Negative line driver enable |

## Verification
The bench times the first strobe exactly: the flag must still be 1 after DIV-1 reference edges and must be 0 after DIV edges. A counter that is off by one, or a flag that is released early, fails that check. Stopping the clock checks that the edge record is cleared at each strobe; a design that never clears it would keep the drivers on forever. Pairs with only the unselected clock running catch a swapped or ignored select. A clock whose period exceeds the interval must make the flag toggle; a detector that stretches edges across intervals would hide it.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic {
    SRC_TX     = 1'b0,
    SRC_SMOOTH = 1'b1
  } src_sel_e;
endpackage

// File: rtl/txw_src_mux.sv
module txw_src_mux
  import txw_pkg::*;
(
  input  logic     tx_clk,
  input  logic     smooth_clk,
  input  src_sel_e sel,
  output logic     watched
);
  always_comb begin
    watched = (sel == SRC_SMOOTH) ? smooth_clk : tx_clk;
  end
endmodule

// File: rtl/txw_edge_sync.sv
module txw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe_q;
  logic [PW-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = async_in;
  end

  for (genvar g = 1; g < PW; g++) begin : g_shift
    always_comb begin
      pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  always_comb begin
    rise = pipe_q[PW-2] & ~pipe_q[PW-1];
  end
endmodule

// File: rtl/txw_strobe_gen.sv
module txw_strobe_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    strobe = (cnt_q == LAST);
    cnt_d  = strobe ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txw_loss_eval.sv
module txw_loss_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic strobe,
  output logic loss
);
  logic seen_q, seen_d;
  logic loss_q, loss_d;
  logic any_edge;

  always_comb begin
    any_edge = seen_q | rise;
    seen_d   = strobe ? 1'b0 : any_edge;
    loss_d   = loss_q;
    if (strobe) loss_d = ~any_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      loss_q <= 1'b1;
    end else begin
      seen_q <= seen_d;
      if (strobe) loss_q <= loss_d;
    end
  end

  always_comb begin
    loss = loss_q;
  end
endmodule

// File: rtl/txclk_watch.sv
module txclk_watch
  import txw_pkg::*;
#(
  parameter int DIV         = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic tx_clk,
  input  logic smooth_clk,
  input  logic src_sel,
  output logic loss,
  output logic drv_en_p,
  output logic drv_en_n
);
  logic watched;
  logic rise;
  logic strobe;
  logic loss_int;
  src_sel_e sel_e;

  always_comb begin
    sel_e = src_sel_e'(src_sel);
  end

  txw_src_mux u_mux (
    .tx_clk     (tx_clk),
    .smooth_clk (smooth_clk),
    .sel        (sel_e),
    .watched    (watched)
  );

  txw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .async_in (watched),
    .rise     (rise)
  );

  txw_strobe_gen #(.DIV(DIV)) u_strobe (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .strobe (strobe)
  );

  txw_loss_eval u_eval (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .rise   (rise),
    .strobe (strobe),
    .loss   (loss_int)
  );

  always_comb begin
    loss     = loss_int;
    drv_en_p = ~loss_int;
    drv_en_n = ~loss_int;
  end
endmodule

// File: rtl/txclk_watch_chk.sv
module txclk_watch_chk #(
  parameter int DIV = 10
) (
  input logic ref_clk,
  input logic rst_n,
  input logic loss,
  input logic drv_en_p,
  input logic drv_en_n
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] ph_q;
  logic          first_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      first_q <= 1'b0;
    end else begin
      if (ph_q == CW'(DIV - 1)) begin
        ph_q    <= '0;
        first_q <= 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // R4
  p_drv_off_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    loss |-> (!drv_en_p && !drv_en_n));

  // R4
  p_drv_on_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !loss |-> (drv_en_p && drv_en_n));

  // R1: the flag moves only on the edge that closes an interval
  p_change_at_strobe_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ph_q != '0) |-> $stable(loss));

  // R8
  p_hold_after_reset_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !first_q |-> loss);
endmodule

bind txclk_watch txclk_watch_chk #(.DIV(DIV)) u_chk (
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .loss     (loss),
  .drv_en_p (drv_en_p),
  .drv_en_n (drv_en_n)
);

// File: tb/test_txclk_watch.sv
module test_txclk_watch;
  localparam int DIV = 10;
  localparam int NV  = 8;
  // {src_sel, tx half-period, smooth half-period, expected loss}; half 0 = stopped
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'd2, 8'd0, 1'b0},
    {1'b0, 8'd0, 8'd2, 1'b1},
    {1'b1, 8'd0, 8'd2, 1'b0},
    {1'b1, 8'd2, 8'd0, 1'b1},
    {1'b1, 8'd3, 8'd3, 1'b0},
    {1'b0, 8'd0, 8'd0, 1'b1},
    {1'b0, 8'd4, 8'd0, 1'b0},
    {1'b1, 8'd0, 8'd4, 1'b0}
  };

  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic tx_clk  = 1'b0;
  logic smooth_clk = 1'b0;
  logic src_sel = 1'b0;
  logic loss, drv_en_p, drv_en_n;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int tx_half = 0;
  int sm_half = 0;

  always #4 ref_clk = ~ref_clk;

  txclk_watch #(.DIV(DIV)) i_txclk_watch (
    .ref_clk(ref_clk), .rst_n(rst_n), .tx_clk(tx_clk), .smooth_clk(smooth_clk),
    .src_sel(src_sel), .loss(loss), .drv_en_p(drv_en_p), .drv_en_n(drv_en_n)
  );

  initial begin
    int tc = 0;
    int sc = 0;
    forever begin
      @(negedge ref_clk);
      if (tx_half > 0) begin
        if (tc >= tx_half - 1) begin tx_clk = ~tx_clk; tc = 0; end
        else tc++;
      end
      if (sm_half > 0) begin
        if (sc >= sm_half - 1) begin smooth_clk = ~smooth_clk; sc = 0; end
        else sc++;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic saw0, saw1;
    // R8: flag and enables during reset
    tx_half = 2;
    repeat (3) @(negedge ref_clk);
    check("R8 loss in reset", loss, 1'b1);
    check("R8 drv_en_p in reset", drv_en_p, 1'b0);
    check("R8 drv_en_n in reset", drv_en_n, 1'b0);
    rst_n = 1'b1;
    // R1/R8: still 1 after DIV-1 edges, cleared on the DIV-th
    wait_cyc(DIV - 1);
    check("R8 loss before first strobe", loss, 1'b1);
    wait_cyc(1);
    check("R1 loss cleared at first strobe", loss, 1'b0);
    check("R4 drv_en_p on", drv_en_p, 1'b1);

    // Table walk: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      src_sel = VEC[i][17];
      tx_half = int'(VEC[i][16:9]);
      sm_half = int'(VEC[i][8:1]);
      wait_cyc(40);
      ok = 1'b1;
      for (int k = 0; k < 2 * DIV; k++) begin
        if (loss !== VEC[i][0] || drv_en_p !== ~VEC[i][0] || drv_en_n !== ~VEC[i][0]) ok = 1'b0;
        wait_cyc(1);
      end
      nchk++;
      if (!ok) begin
        nfail++;
        $display("FAIL R2/R3/R5/R6 vector %0d: actual loss %b expected %b", i, loss, VEC[i][0]);
      end
    end

    // R7: stop the clock, flag must rise after the record is cleared
    src_sel = 1'b0; tx_half = 2; sm_half = 0;
    wait_cyc(40);
    check("R7 running before stop", loss, 1'b0);
    tx_half = 0;
    wait_cyc(4);
    check("R7 still 0 just after stop", loss, 1'b0);
    wait_cyc(21);
    check("R7 loss after stop", loss, 1'b1);
    check("R4 drv_en_n off", drv_en_n, 1'b0);

    // R3/R1: clock period longer than the interval makes the flag toggle
    tx_half = 15;
    wait_cyc(20);
    saw0 = 1'b0; saw1 = 1'b0;
    for (int k = 0; k < 150; k++) begin
      if (loss === 1'b0) saw0 = 1'b1;
      if (loss === 1'b1) saw1 = 1'b1;
      wait_cyc(1);
    end
    check("R3 slow clock shows loss", saw1, 1'b1);
    check("R2 slow clock shows presence", saw0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule